// File: doc/BRIEF.md
# Three-Port Parallel I/O Controller

This block gives a processor three byte-wide parallel ports (A, B and C) through a small register window. The window sits on a byte bus with a 2-bit register offset, a chip select, a read strobe and a write strobe. Offsets 0, 1 and 2 reach ports A, B and C. Offset 3 holds a mode word that is write-only. It sets the direction of port A, of port B, and of each nibble of port C on its own.

A port bit set as output drives its latched value and raises its output enable. A port bit set as input leaves its enable low. Reading that bit returns the level on the external pin at the moment the read is taken.

A small access sequencer turns each strobe into exactly one register action. It has three states:
- `ST_IDLE` waits for a strobe.
- `ST_WR_HOLD` waits for a write strobe to be released.
- `ST_RD_HOLD` waits for a read strobe to be released.

It has four transitions:
- IDLE→WR_HOLD when a select with write alone is seen. The write is performed on that edge.
- IDLE→RD_HOLD when a select with read alone is seen. The read data is captured on that edge.
- WR_HOLD→IDLE when the select or the write strobe drops.
- RD_HOLD→IDLE when the select or the read strobe drops.

Top module: `pio_controller`

## Requirements
- R1: After reset every port bit is an input. All three output-enable buses are 0x00, all output buses are 0x00 and the read data is 0x00.
- R2: A mode word is accepted when bit 7 is 1 and bits 6, 5 and 2 are 0. In an accepted word, a bit set to 1 makes its field an input and a bit set to 0 makes it an output. Bit 4 sets port A, bit 1 sets port B, bit 3 sets the upper nibble of port C and bit 0 sets its lower nibble. For example, 0x90 makes A an input and everything else an output, and 0x80 makes everything an output. Each output-enable bit is 1 exactly when its bit is an output, from the cycle after the accepting edge.
- R3: A mode word whose bit 7 is 0, or whose bit 6, 5 or 2 is 1, is ignored. Directions and output latches keep their values.
- R4: Accepting a mode word clears all three output latches to 0x00.
- R5: A write to offset 0, 1 or 2 loads that port's latch, whatever its direction. The port's output bus shows the value from the cycle after the accepting edge.
- R6: A read of offset 0, 1 or 2 returns, bit by bit, the pin level for input bits and the latch value for output bits. The value is sampled on the accepting edge and held on the read-data bus until the next read.
- R7: A read of offset 3 returns 0x00.
- R8: One strobe performs one action. While a strobe stays asserted, later data or pin changes have no effect. A cycle with both strobes high, or with chip select low, does nothing.
- R9: The two nibbles of port C keep separate directions. In a mixed setting, a read returns pins for one nibble and latch bits for the other.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs | input | 1 | Chip select, active high |
| rd | input | 1 | Read strobe, active high |
| wr | input | 1 | Write strobe, active high |
| addr | input | 2 | Register offset: 0 = A, 1 = B, 2 = C, 3 = mode |
| wdata | input | 8 | Write data |
| rdata | output | 8 | Registered read data |
| pa_in | input | 8 | Port A pin levels |
| pa_out | output | 8 | Port A output latch |
| pa_oe | output | 8 | Port A output enables |
| pb_in | input | 8 | Port B pin levels |
| pb_out | output | 8 | Port B output latch |
| pb_oe | output | 8 | Port B output enables |
| pc_in | input | 8 | Port C pin levels |
| pc_out | output | 8 | Port C output latch |
| pc_oe | output | 8 | Port C output enables |

## Verification
The hardest case to reach from the ports is a rejected mode word arriving while the latches hold nonzero data. An idle block would hide a faulty clear or a faulty direction change.

To reach it, the stimulus first sets every port to output and loads distinct nonzero patterns into all three latches. It then offers each of the 256 possible mode words in turn, reloading the latches before each one. After every word it compares enables and outputs with what the acceptance rule predicts.

Held strobes are driven over several cycles while the write data and the pin levels change underneath. This shows that only the first edge acts.

// File: rtl/pio_pkg.sv
package pio_pkg;
    localparam int BYTE_W = 8;
    localparam int HALF_W = BYTE_W / 2;
    localparam int N_PORTS = 3;

    localparam logic [1:0] OFS_A    = 2'd0;
    localparam logic [1:0] OFS_B    = 2'd1;
    localparam logic [1:0] OFS_C    = 2'd2;
    localparam logic [1:0] OFS_MODE = 2'd3;

    typedef enum logic [1:0] {
        ST_IDLE    = 2'd0,
        ST_WR_HOLD = 2'd1,
        ST_RD_HOLD = 2'd2
    } bus_state_t;

    // 1 = input, 0 = output
    typedef struct packed {
        logic a_in;
        logic b_in;
        logic cu_in;
        logic cl_in;
    } dir_cfg_t;
endpackage

// File: rtl/pio_bus_fsm.sv
module pio_bus_fsm
    import pio_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic cs,
    input  logic rd,
    input  logic wr,
    output logic wr_go,
    output logic rd_go
);
    bus_state_t state_q, state_d;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) state_q <= ST_IDLE;
        else        state_q <= state_d;
    end

    always_comb begin
        state_d = state_q;
        wr_go   = 1'b0;
        rd_go   = 1'b0;
        unique case (state_q)
            ST_IDLE: begin
                if (cs && wr && !rd) begin
                    wr_go   = 1'b1;
                    state_d = ST_WR_HOLD;
                end else if (cs && rd && !wr) begin
                    rd_go   = 1'b1;
                    state_d = ST_RD_HOLD;
                end
            end
            ST_WR_HOLD: if (!(cs && wr)) state_d = ST_IDLE;
            ST_RD_HOLD: if (!(cs && rd)) state_d = ST_IDLE;
            default:    state_d = ST_IDLE;
        endcase
    end

    p_one_kind_r8: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0({wr_go, rd_go}));
    p_single_write_r8: assert property (@(posedge clk) disable iff (!rst_n)
        wr_go |=> !wr_go);
    p_single_read_r8: assert property (@(posedge clk) disable iff (!rst_n)
        rd_go |=> !rd_go);
endmodule

// File: rtl/pio_mode_reg.sv
module pio_mode_reg
    import pio_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [BYTE_W-1:0] wdata,
    output dir_cfg_t          dir,
    output logic              clr_latches
);
    logic word_ok;

    assign word_ok     = wdata[7] & ~wdata[6] & ~wdata[5] & ~wdata[2];
    assign clr_latches = wr_en & word_ok;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            dir <= '{a_in: 1'b1, b_in: 1'b1, cu_in: 1'b1, cl_in: 1'b1};
        end else if (clr_latches) begin
            dir <= '{a_in: wdata[4], b_in: wdata[1], cu_in: wdata[3], cl_in: wdata[0]};
        end
    end

    p_reject_bad_word_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && (!wdata[7] || wdata[6] || wdata[5] || wdata[2])) |=> $stable(dir));
    p_accept_fields_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wdata[7] && !wdata[6] && !wdata[5] && !wdata[2])
            |=> (dir.a_in == $past(wdata[4]) && dir.b_in == $past(wdata[1])));
endmodule

// File: rtl/pio_port.sv
module pio_port #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         wr_en,
    input  logic         clr,
    input  logic [W-1:0] wdata,
    input  logic [W-1:0] dir_in,
    input  logic [W-1:0] pin_in,
    output logic [W-1:0] pin_out,
    output logic [W-1:0] pin_oe,
    output logic [W-1:0] rd_val
);
    logic [W-1:0] latch_q;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)     latch_q <= '0;
        else if (clr)   latch_q <= '0;
        else if (wr_en) latch_q <= wdata;
    end

    assign pin_out = latch_q;
    assign pin_oe  = ~dir_in;

    for (genvar i = 0; i < W; i++) begin : g_bit
        assign rd_val[i] = dir_in[i] ? pin_in[i] : latch_q[i];
    end

    p_latch_clear_r4: assert property (@(posedge clk) disable iff (!rst_n)
        clr |=> (pin_out == '0));
    p_latch_load_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !clr) |=> (pin_out == $past(wdata)));
    p_latch_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (!wr_en && !clr) |=> $stable(pin_out));
endmodule

// File: rtl/pio_controller.sv
module pio_controller
    import pio_pkg::*;
(
    input  logic        clk,
    input  logic        rst_n,
    input  logic        cs,
    input  logic        rd,
    input  logic        wr,
    input  logic [1:0]  addr,
    input  logic [7:0]  wdata,
    output logic [7:0]  rdata,
    input  logic [7:0]  pa_in,
    output logic [7:0]  pa_out,
    output logic [7:0]  pa_oe,
    input  logic [7:0]  pb_in,
    output logic [7:0]  pb_out,
    output logic [7:0]  pb_oe,
    input  logic [7:0]  pc_in,
    output logic [7:0]  pc_out,
    output logic [7:0]  pc_oe
);
    logic     wr_go, rd_go, clr_latches, mode_wr;
    dir_cfg_t dir;

    logic [N_PORTS-1:0][BYTE_W-1:0] dir_vec, pins, outs, oes, rvals;
    logic [N_PORTS-1:0]             port_wr;

    pio_bus_fsm u_fsm (
        .clk   (clk),
        .rst_n (rst_n),
        .cs    (cs),
        .rd    (rd),
        .wr    (wr),
        .wr_go (wr_go),
        .rd_go (rd_go)
    );

    assign mode_wr = wr_go && (addr == OFS_MODE);

    pio_mode_reg u_mode (
        .clk         (clk),
        .rst_n       (rst_n),
        .wr_en       (mode_wr),
        .wdata       (wdata),
        .dir         (dir),
        .clr_latches (clr_latches)
    );

    assign dir_vec[0] = {BYTE_W{dir.a_in}};
    assign dir_vec[1] = {BYTE_W{dir.b_in}};
    assign dir_vec[2] = {{HALF_W{dir.cu_in}}, {HALF_W{dir.cl_in}}};
    assign pins[0]    = pa_in;
    assign pins[1]    = pb_in;
    assign pins[2]    = pc_in;

    for (genvar p = 0; p < N_PORTS; p++) begin : g_port
        assign port_wr[p] = wr_go && (addr == 2'(p));
        pio_port #(.W(BYTE_W)) u_port (
            .clk     (clk),
            .rst_n   (rst_n),
            .wr_en   (port_wr[p]),
            .clr     (clr_latches),
            .wdata   (wdata),
            .dir_in  (dir_vec[p]),
            .pin_in  (pins[p]),
            .pin_out (outs[p]),
            .pin_oe  (oes[p]),
            .rd_val  (rvals[p])
        );
    end

    assign pa_out = outs[0];
    assign pb_out = outs[1];
    assign pc_out = outs[2];
    assign pa_oe  = oes[0];
    assign pb_oe  = oes[1];
    assign pc_oe  = oes[2];

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata <= '0;
        end else if (rd_go) begin
            unique case (addr)
                OFS_A:    rdata <= rvals[0];
                OFS_B:    rdata <= rvals[1];
                OFS_C:    rdata <= rvals[2];
                OFS_MODE: rdata <= '0;
                default:  rdata <= '0;
            endcase
        end
    end

    p_mode_read_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_go && addr == OFS_MODE) |=> (rdata == '0));
    p_rdata_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !rd_go |=> $stable(rdata));
    p_idle_cs_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !cs |=> ($stable(pa_out) && $stable(pb_out) && $stable(pc_out) && $stable(pa_oe)));
endmodule

// File: tb/tb_pio_controller.sv
module tb_pio_controller;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       cs = 1'b0, rd = 1'b0, wr = 1'b0;
    logic [1:0] addr = 2'd0;
    logic [7:0] wdata = 8'h00;
    logic [7:0] rdata;
    logic [7:0] pa_in = 8'h00, pb_in = 8'h00, pc_in = 8'h00;
    logic [7:0] pa_out, pa_oe, pb_out, pb_oe, pc_out, pc_oe;

    int checks = 0;
    int errors = 0;

    // bench model: 1 = input
    logic ea = 1'b1, eb = 1'b1, ecu = 1'b1, ecl = 1'b1;
    logic [7:0] la = 8'h00, lb = 8'h00, lc = 8'h00;

    always #4 clk = ~clk;

    pio_controller dut (
        .clk(clk), .rst_n(rst_n), .cs(cs), .rd(rd), .wr(wr), .addr(addr),
        .wdata(wdata), .rdata(rdata),
        .pa_in(pa_in), .pa_out(pa_out), .pa_oe(pa_oe),
        .pb_in(pb_in), .pb_out(pb_out), .pb_oe(pb_oe),
        .pc_in(pc_in), .pc_out(pc_out), .pc_oe(pc_oe)
    );

    task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic logic word_valid(input logic [7:0] w);
        return w[7] && !w[6] && !w[5] && !w[2];
    endfunction

    task automatic do_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = a; wdata = d;
        @(negedge clk);
        cs = 1'b0; wr = 1'b0;
        @(negedge clk);
        if (a == 2'd3) begin
            if (word_valid(d)) begin
                ea = d[4]; eb = d[1]; ecu = d[3]; ecl = d[0];
                la = 8'h00; lb = 8'h00; lc = 8'h00;
            end
        end else if (a == 2'd0) la = d;
        else if (a == 2'd1) lb = d;
        else lc = d;
    endtask

    task automatic do_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = a;
        @(negedge clk);
        d = rdata;
        cs = 1'b0; rd = 1'b0;
        @(negedge clk);
    endtask

    function automatic logic [7:0] exp_read(input logic [1:0] a);
        logic [7:0] dv;
        case (a)
            2'd0: begin dv = {8{ea}}; return (dv & pa_in) | (~dv & la); end
            2'd1: begin dv = {8{eb}}; return (dv & pb_in) | (~dv & lb); end
            2'd2: begin dv = {{4{ecu}}, {4{ecl}}}; return (dv & pc_in) | (~dv & lc); end
            default: return 8'h00;
        endcase
    endfunction

    task automatic check_outputs(input string req);
        chk({req, " pa_oe"}, {24'd0, pa_oe}, {24'd0, {8{~ea}}});
        chk({req, " pb_oe"}, {24'd0, pb_oe}, {24'd0, {8{~eb}}});
        chk({req, " pc_oe"}, {24'd0, pc_oe}, {24'd0, {{4{~ecu}}, {4{~ecl}}}});
        chk({req, " pa_out"}, {24'd0, pa_out}, {24'd0, la});
        chk({req, " pb_out"}, {24'd0, pb_out}, {24'd0, lb});
        chk({req, " pc_out"}, {24'd0, pc_out}, {24'd0, lc});
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual running expected finished");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        logic [7:0] r;
        repeat (3) @(negedge clk);
        // R1: reset state
        chk("R1 rdata", {24'd0, rdata}, 32'd0);
        check_outputs("R1");
        rst_n = 1'b1;
        @(negedge clk);
        check_outputs("R1 after release");

        // R2 R4 R5 R6 R7 R9: every direction combination
        for (int c = 0; c < 16; c++) begin
            logic [7:0] w;
            w = 8'h80 | {3'b000, c[3], c[2], 1'b0, c[1], c[0]};
            do_write(2'd0, 8'hFF); // preload so the clear is visible
            do_write(2'd3, w);
            check_outputs("R2 R4 mode sweep");
            for (int k = 0; k < 4; k++) begin
                do_write(2'd0, 8'(8'h13 * (k + 1) + c));
                do_write(2'd1, 8'(8'h5A ^ (k * 37 + c)));
                do_write(2'd2, 8'(8'hC3 + k * 11 + c * 3));
                check_outputs("R5 port write");
                pa_in = 8'(8'h97 + k * 29 + c);
                pb_in = 8'(~(k * 53 + c * 7));
                pc_in = 8'(8'h3C ^ (k * 17 + c * 5));
                for (int a = 0; a < 4; a++) begin
                    do_read(2'(a), r);
                    chk(a == 3 ? "R7 mode read" : (a == 2 ? "R9 R6 port C read" : "R6 port read"),
                        {24'd0, r}, {24'd0, exp_read(2'(a))});
                end
            end
        end

        // R2 R3: all 256 mode words against loaded latches
        for (int w = 0; w < 256; w++) begin
            do_write(2'd3, 8'h80);
            do_write(2'd0, 8'h5A);
            do_write(2'd1, 8'hA5);
            do_write(2'd2, 8'h3C);
            do_write(2'd3, 8'(w));
            check_outputs(word_valid(8'(w)) ? "R2 accepted word" : "R3 rejected word");
        end

        // R8: held write strobe, data changes mid-strobe
        do_write(2'd3, 8'h80);
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; addr = 2'd0; wdata = 8'h11;
        @(negedge clk); wdata = 8'h22;
        @(negedge clk); wdata = 8'h33;
        @(negedge clk); cs = 1'b0; wr = 1'b0;
        @(negedge clk);
        chk("R8 held write", {24'd0, pa_out}, 32'h11);
        la = 8'h11;

        // R8: both strobes together are ignored
        @(negedge clk);
        cs = 1'b1; wr = 1'b1; rd = 1'b1; addr = 2'd0; wdata = 8'h44;
        @(negedge clk); cs = 1'b0; wr = 1'b0; rd = 1'b0;
        @(negedge clk);
        chk("R8 rd and wr together", {24'd0, pa_out}, 32'h11);

        // R8: write without chip select is ignored
        @(negedge clk);
        wr = 1'b1; addr = 2'd3; wdata = 8'h9B;
        @(negedge clk); wr = 1'b0;
        @(negedge clk);
        chk("R8 no cs oe", {24'd0, pa_oe}, 32'hFF);
        chk("R8 no cs out", {24'd0, pa_out}, 32'h11);

        // R8 R6: held read, pins change mid-strobe
        do_write(2'd3, 8'h90);
        pa_in = 8'h97;
        @(negedge clk);
        cs = 1'b1; rd = 1'b1; addr = 2'd0;
        @(negedge clk); pa_in = 8'h00;
        @(negedge clk); pa_in = 8'hFF;
        @(negedge clk);
        chk("R8 held read", {24'd0, rdata}, 32'h97);
        cs = 1'b0; rd = 1'b0;
        @(negedge clk);
        chk("R6 rdata held", {24'd0, rdata}, 32'h97);
        do_read(2'd0, r);
        chk("R6 new read", {24'd0, r}, 32'hFF);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end
endmodule